// File: doc/BRIEF.md
# Periodic Rank-Drop Stream Sampler

This block sits in a streaming datapath and thins a stream in a fixed pattern. It splits the input into back-to-back groups of l+1 items and removes exactly one item, the one at rank k inside each group. The other l items pass through unchanged and in their original order, so the output carries l of every l+1 inputs. The data values never affect which items are kept.

Both sides use a valid/ready handshake. A single output register holds each forwarded item until the consumer takes it. The item at the drop rank is accepted and discarded even while the consumer is stalled. The group length l and the drop rank k come either from elaboration parameters or from configuration inputs. Those inputs must stay constant while the block is out of reset. An illegal fixed setting stops elaboration.

Top module: `rank_drop_sampler`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, out_valid is 0 and in_ready is 1. The first item accepted after reset is rank 0 of group 0.
- R2: Output item number l*i+j carries input item (l+1)*i+j when j<k, and input item (l+1)*i+j+1 when k<=j<l. Items are counted from 0 after reset, and rank is the item's position inside its group of l+1.
- R3: When the next input item has rank k, in_ready is 1 whatever the state of out_valid or out_ready. Accepting that item creates no output beat.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged in the next cycle.
- R5: When the next item does not have rank k, the output register is full and out_ready is 0, in_ready is 0.
- R6: With out_ready held at 1, in_ready is 1 in every cycle. A continuously valid input is therefore accepted at one item per cycle.
- R7: Rank counting wraps after rank l back to 0. This holds for k=0, for k=l and for l=1.
- R8: Legal settings are 1<=l<=MAX_LEN and 0<=k<=l. With USE_CFG=0, illegal parameters fail elaboration. With USE_CFG=1, cfg_len and cfg_rank must be legal and stable whenever reset is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | CNT_W | Kept items per group (l) when USE_CFG=1 |
| cfg_rank | input | CNT_W | Rank of the dropped item (k) when USE_CFG=1 |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block accepts the input item |
| in_data | input | DATA_W | Input item |
| out_valid | output | 1 | Output register holds an item |
| out_ready | input | 1 | Consumer takes the output item |
| out_data | output | DATA_W | Output item |

## Verification
If the rank counter is off by one, or wraps at the wrong value, the first wrong item appears at the port within one group. That item is either a value that should have been dropped or a skipped value that should have been kept, and it shows at the first output handshake after the error. A wrong output-register state is visible within a cycle. A lost hold changes out_data under a stall. A refused drop lowers in_ready at rank k while the consumer is stalled. A wrongly accepted input overwrites a pending item, which the next output comparison catches as a missing value.

// File: rtl/rank_drop_sampler.sv
module rank_drop_sampler #(
  parameter int DATA_W    = 8,
  parameter int MAX_LEN   = 15,
  parameter bit USE_CFG   = 1'b0,
  parameter int BLK_LEN   = 3,
  parameter int DROP_RANK = 1,
  localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_len,
  input  logic [CNT_W-1:0]  cfg_rank,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  if (BLK_LEN < 1 || BLK_LEN > MAX_LEN || DROP_RANK < 0 || DROP_RANK > BLK_LEN) begin : g_bad_cfg
    $error("rank_drop_sampler: illegal BLK_LEN/DROP_RANK");
  end

  logic [CNT_W-1:0]  len_e, rank_e, pos_q;
  logic              ov_q, at_drop, take;
  logic [DATA_W-1:0] od_q;

  assign len_e   = USE_CFG ? cfg_len  : CNT_W'(BLK_LEN);
  assign rank_e  = USE_CFG ? cfg_rank : CNT_W'(DROP_RANK);
  assign at_drop = (pos_q == rank_e);

  assign in_ready  = at_drop | ~ov_q | out_ready;
  assign take      = in_valid & in_ready;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      if (take) pos_q <= (pos_q == len_e) ? '0 : pos_q + 1'b1;
      if (take && !at_drop) ov_q <= 1'b1;
      else if (out_ready)   ov_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !at_drop) od_q <= in_data;
  end

endmodule

// File: rtl/rank_drop_sampler_chk.sv
module rank_drop_sampler_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter bit USE_CFG = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  pos,
  input logic [CNT_W-1:0]  len_e,
  input logic [CNT_W-1:0]  rank_e
);

  // R3
  drop_always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == rank_e) |-> in_ready);

  // R3
  drop_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pos == rank_e) |=> (out_valid == $past(out_valid && !out_ready)));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  stall_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && pos != rank_e) |-> !in_ready);

  // R6
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R7
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= len_e);

  // R8
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !USE_CFG || (len_e != '0 && rank_e <= len_e));

  // R8
  cfg_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(len_e) && $stable(rank_e));

endmodule

bind rank_drop_sampler rank_drop_sampler_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .USE_CFG(USE_CFG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .pos(pos_q), .len_e(len_e), .rank_e(rank_e)
);

// File: tb/tb_rank_drop_sampler.sv
module tb_rank_drop_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int ML  = 15;
  localparam int CW  = $clog2(ML + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_len = CW'(3), cfg_rank = CW'(1);
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_drop_sampler #(.DATA_W(DW), .MAX_LEN(ML), .USE_CFG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_rank(cfg_rank),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  function automatic logic [DW-1:0] val(input int idx);
    return DW'(idx * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic t_reset(input int l, input int k);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cfg_len = CW'(l); cfg_rank = CW'(k);
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  // R2 R6 R7: stream with a mode: 0 full flow, 1 gappy valid, 2 gappy ready, 3 both
  task automatic t_stream(input int l, input int k, input int n_out, input int mode);
    int ic = 0, oc = 0, guard = 0;
    bit hold = 1'b0;
    logic [DW-1:0] hold_d = '0;
    t_reset(l, k);
    while (oc < n_out && guard < 20000) begin
      guard++;
      step_lfsr();
      in_valid  = (mode == 1 || mode == 3) ? lfsr[0] : 1'b1;
      out_ready = (mode == 2 || mode == 3) ? lfsr[3] : 1'b1;
      in_data   = val(ic);
      #1;
      if (hold) chk(out_valid && out_data == hold_d, "R4 hold", int'(out_data), int'(hold_d));
      if (mode == 0) chk(in_ready == 1'b1, "R6 full rate", in_ready, 1);
      if (out_valid && out_ready) begin
        int i = oc / l, j = oc % l;
        int src = (l + 1) * i + j + ((j >= k) ? 1 : 0);
        chk(out_data == val(src), $sformatf("R2/R7 l=%0d k=%0d out#%0d", l, k, oc),
            int'(out_data), int'(val(src)));
        oc++;
      end
      hold = out_valid && !out_ready;
      hold_d = out_data;
      if (in_valid && in_ready) ic++;
      @(negedge clk);
    end
    chk(oc == n_out, "R2 output count", oc, n_out);
    in_valid = 1'b0;
  endtask

  // R3 R4 R5: drop rank accepted under a stalled full register, l=3 k=2
  task automatic t_drop_stall();
    t_reset(3, 2);
    in_valid = 1'b1; in_data = val(0); out_ready = 1'b0;
    #1; chk(in_ready == 1'b1, "R5 empty accepts", in_ready, 1);
    @(negedge clk);
    in_data = val(1);
    #1; chk(in_ready == 1'b0, "R5 stall on full", in_ready, 0);
    @(negedge clk);
    out_ready = 1'b1;
    #1; chk(out_valid && out_data == val(0), "R2 first item", int'(out_data), int'(val(0)));
    chk(in_ready == 1'b1, "R6 drain and refill", in_ready, 1);
    @(negedge clk);
    out_ready = 1'b0; in_data = val(2);
    #1; chk(in_ready == 1'b1, "R3 drop taken while stalled", in_ready, 1);
    @(negedge clk);
    in_data = val(3);
    #1; chk(out_valid && out_data == val(1), "R3 drop made no beat", int'(out_data), int'(val(1)));
    chk(in_ready == 1'b0, "R5 stall after drop", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1; chk(out_valid && out_data == val(1), "R4 held item", int'(out_data), int'(val(1)));
    @(negedge clk);
    #1; chk(out_valid == 1'b0, "R3 no extra beat", out_valid, 0);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_up();
      end
    end
  end

  initial begin
    t_drop_stall();
    t_stream(3, 1, 60, 0);
    t_stream(3, 1, 90, 3);
    t_stream(4, 0, 80, 1);   // R7 k=0
    t_stream(4, 4, 80, 2);   // R7 k=l
    t_stream(1, 0, 40, 3);   // R7 l=1
    t_stream(1, 1, 40, 0);
    t_stream(15, 7, 120, 3);
    finish_up();
  end
endmodule